// File: doc/BRIEF.md
# SerDes Power-Down and Clock-Mode Controller

This block is the control state machine for one end of a serializer/deserializer link. It runs on a free-running sample clock. It decodes a two-bit mode select, and an all-zero value requests power-down. In power-down the block holds the link's internal logic in reset. It turns off the PLL and the differential receivers, and it floats every output driver. It also forces the single-ended inputs to a defined level. When the block leaves power-down, it releases the internal reset one cycle before any buffer is switched on.

In the serialize direction the block picks the serialization clock source. After a power-up with no reference activity, it uses an external free-running bit clock that arrives on the differential input. Once a valid reference clock is seen, it moves to reference-clock mode and enables the PLL. This choice is sticky. If the reference later stops, the block stays in reference-clock mode. Only a power-down followed by a power-up with no reference activity returns it to external-clock mode. In reference-clock mode, data capture waits until the PLL lock flag has been stable for a set number of cycles.

The reference is judged valid by counting its synchronized rising edges over a fixed window of sample-clock cycles. The analog PLL and the buffers are outside this block. They appear only as enables and status inputs.

Top module: `serdes_pwr_ctrl`

## Requirements
- R1: One cycle after `mode_sel` reads 2'b00, the block is in power-down. In that state `core_rst_n`, `pll_en`, `diff_in_en`, `deser_en`, `capture_en`, `diff_out_oe` and `se_out_oe` are all 0, and `se_in_force` is 1. This is also the state while `rst_n` is low.
- R2: In the first cycle after a nonzero `mode_sel` is sampled in power-down, `core_rst_n` is 1 and every enable and output-enable is still 0. The mode-dependent enables follow in the next cycle.
- R3: The reference input passes through a two-flop synchronizer, and its rising edges are counted over each window of WIN_CYCLES sample cycles. At the end of a window, the reference is valid when the count is at least MIN_EDGES. A reference with fewer edges per window never leaves external-clock mode.
- R4: When the block powers up with no valid reference, `clk_src_ref` is 0 and `pll_en` is 0. In the serialize direction, `diff_in_en` is 1 (it carries the external bit clock) and `capture_en` is 1.
- R5: When a valid reference is detected while the external clock is selected, `clk_src_ref` goes to 1, `pll_en` goes to 1 and `diff_in_en` drops to 0 (serialize direction).
- R6: `clk_src_ref` stays 1 after the reference stops, for as long as the block is not powered down.
- R7: On leaving power-down, `clk_src_ref` takes the reference-valid state of that moment. A power-up with no reference activity therefore returns the block to external-clock mode. A power-up with a running reference gives reference-clock mode straight away.
- R8: In reference-clock mode, `capture_en` rises only after `pll_locked` has been 1 for LOCK_CYCLES consecutive sample cycles while the PLL is enabled. It returns to 0 one cycle after `pll_locked` drops.
- R9: With `dir_ser`=1 (serialize), `deser_en` is 0, `word_clk_hi` is 1 and `diff_out_oe` is 1. With `dir_ser`=0 (deserialize), `deser_en` is 1, `diff_in_en` is 1, and `word_clk_hi`, `diff_out_oe` and `capture_en` are 0.
- R10: `pll_en` is 1 only when the block is active, in reference-clock mode, and a valid reference has been seen since the last power-down. It is therefore 0 in the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Mode select; 2'b00 requests power-down |
| dir_ser | input | 1 | 1 = serialize direction, 0 = deserialize |
| ref_clk_in | input | 1 | Reference clock, asynchronous to `clk` |
| pll_locked | input | 1 | Lock flag from the PLL |
| core_rst_n | output | 1 | Active-low reset to the link's internal logic |
| pll_en | output | 1 | PLL and reference enable |
| diff_in_en | output | 1 | Differential input buffer enable |
| diff_out_oe | output | 1 | Differential output driver enable (0 = high impedance) |
| se_out_oe | output | 1 | Single-ended output driver enable (0 = high impedance) |
| se_in_force | output | 1 | Forces single-ended inputs to a defined level |
| clk_src_ref | output | 1 | 1 = reference-clock serialization, 0 = external bit clock |
| deser_en | output | 1 | Deserializer path enable |
| word_clk_hi | output | 1 | Holds the parallel word-clock output high |
| capture_en | output | 1 | Parallel data capture permitted |

## Verification
The bench builds the block with WIN_CYCLES=16, MIN_EDGES=3 and LOCK_CYCLES=5. With these values, reference detection and its loss settle within a few dozen cycles, so one run can cover several power-down and power-up cycles. A reference toggling every two cycles gives four edges per window and is accepted. A reference toggling every eight cycles gives a single edge per window and exercises the threshold from below. The short lock count lets the bench check the exact cycle in which capture becomes permitted, and check that it is withdrawn when the lock flag drops.

// File: rtl/serdes_pwr_pkg.sv
// Shared types for the SerDes power-down and clock-mode controller.
// Assumes: a single sample-clock domain for all state.
package serdes_pwr_pkg;

    // Power sequencing states.
    typedef enum logic [1:0] {
        PW_OFF     = 2'd0,
        PW_RELEASE = 2'd1,
        PW_ACTIVE  = 2'd2
    } pwr_state_t;

    // Mode-select code that requests power-down.
    localparam logic [1:0] MODE_SLEEP = 2'b00;

endpackage

// File: rtl/serdes_ref_detect.sv
// Reference-clock activity detector.
// Synchronizes the asynchronous reference through two flops, counts its
// rising edges over a window of WIN_CYCLES sample cycles, and updates
// ref_valid at each window end (count >= MIN_EDGES).
// Assumes: the reference's high and low phases each last longer than one
// sample-clock period. The detector runs during power-down as well.
module serdes_ref_detect #(
    parameter int WIN_CYCLES = 64,
    parameter int MIN_EDGES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_raw,
    output logic ref_valid
);
    localparam int WIN_W  = $clog2(WIN_CYCLES + 1);
    localparam int EDGE_W = $clog2(MIN_EDGES + 1);

    logic [2:0]        ref_pipe;
    logic [WIN_W-1:0]  win_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              rise;
    logic              win_end;
    logic [EDGE_W:0]   edge_total;

    assign rise       = ref_pipe[1] & ~ref_pipe[2];
    assign win_end    = (win_cnt == WIN_W'(WIN_CYCLES - 1));
    assign edge_total = {1'b0, edge_cnt} + (EDGE_W + 1)'(rise);

    // Two synchronizing flops plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_pipe <= '0;
        else        ref_pipe <= {ref_pipe[1:0], ref_raw};
    end

    // Window timer over the sample clock.
    always_ff @(posedge clk) begin
        if (!rst_n || win_end) win_cnt <= '0;
        else                   win_cnt <= win_cnt + 1'b1;
    end

    // Saturating edge count within the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || win_end)                          edge_cnt <= '0;
        else if (rise && edge_cnt != EDGE_W'(MIN_EDGES)) edge_cnt <= edge_cnt + 1'b1;
    end

    // Verdict latched at every window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_valid <= 1'b0;
        else if (win_end) ref_valid <= (edge_total >= (EDGE_W + 1)'(MIN_EDGES));
    end

    // R3: the verdict only moves on a window boundary.
    a_r3_valid_on_window: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(ref_valid));

    // R3: a window with no edge at all leaves the reference invalid.
    a_r3_silent_window: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && edge_cnt == '0 && !rise) |=> !ref_valid);

endmodule

// File: rtl/serdes_lock_qual.sv
// PLL lock qualifier.
// Counts consecutive sample cycles with the lock flag high while the PLL
// is enabled; lock_ok is asserted once LOCK_CYCLES have been reached.
// Assumes: pll_locked is already synchronous to clk.
module serdes_lock_qual #(
    parameter int LOCK_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pll_locked,
    output logic lock_ok
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] run_cnt;

    // Consecutive-lock counter, cleared by any dropout or PLL disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !pll_locked)    run_cnt <= '0;
        else if (run_cnt != CNT_W'(LOCK_CYCLES)) run_cnt <= run_cnt + 1'b1;
    end

    assign lock_ok = (run_cnt == CNT_W'(LOCK_CYCLES));

    // R8: a qualified lock implies the flag was high on the last edge.
    a_r8_lock_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> ($past(pll_locked) && $past(enable)));

    // R8: a dropout withdraws the qualification on the next edge.
    a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> !lock_ok);

endmodule

// File: rtl/serdes_pwr_fsm.sv
// Power sequencing state machine with sticky clock-source latch.
// Tracks power-down, the one-cycle reset release, and the active state.
// Also holds the reference-mode latch and the loss-of-reference arm flag.
// Assumes: mode_sel is quasi-static and synchronous to clk.
module serdes_pwr_fsm
    import serdes_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       ref_valid,
    output pwr_state_t state,
    output logic       src_ref,
    output logic       los_armed
);
    logic       pd_req;
    pwr_state_t state_nx;

    assign pd_req = (mode_sel == MODE_SLEEP);

    // Next-state selection: power-down wins from any state.
    always_comb begin
        state_nx = state;
        if (pd_req) begin
            state_nx = PW_OFF;
        end else begin
            case (state)
                PW_OFF:     state_nx = PW_RELEASE;
                PW_RELEASE: state_nx = PW_ACTIVE;
                PW_ACTIVE:  state_nx = PW_ACTIVE;
                default:    state_nx = PW_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PW_OFF;
        else        state <= state_nx;
    end

    // Sticky source latch: sampled on power-down exit, set-only when up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ref <= 1'b0;
        end else if (state == PW_OFF) begin
            if (!pd_req) src_ref <= ref_valid;
        end else begin
            src_ref <= src_ref | ref_valid;
        end
    end

    // Loss-of-reference arm: set in power-down, cleared by a valid reference.
    always_ff @(posedge clk) begin
        if (!rst_n || state == PW_OFF) los_armed <= 1'b1;
        else if (ref_valid)            los_armed <= 1'b0;
    end

    // R1: a sleep code always lands in power-down on the next edge.
    a_r1_enter_off: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> (state == PW_OFF));

    // R6: reference mode never falls back while powered.
    a_r6_src_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PW_OFF && src_ref) |=> src_ref);

    // R7: the source chosen at power-up follows the reference verdict then.
    a_r7_exit_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_OFF && !pd_req) |=> (src_ref == $past(ref_valid)));

endmodule

// File: rtl/serdes_pwr_ctrl.sv
// SerDes power-down and clock-mode controller (top).
// Combines reference detection, lock qualification and power sequencing,
// and decodes the state into buffer, PLL and datapath controls.
// Assumes: all outputs feed analog enables or downstream logic that
// tolerates decode from registered state; ref_clk_in is asynchronous.
module serdes_pwr_ctrl
    import serdes_pwr_pkg::*;
#(
    parameter int WIN_CYCLES  = 64,
    parameter int MIN_EDGES   = 8,
    parameter int LOCK_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       dir_ser,
    input  logic       ref_clk_in,
    input  logic       pll_locked,
    output logic       core_rst_n,
    output logic       pll_en,
    output logic       diff_in_en,
    output logic       diff_out_oe,
    output logic       se_out_oe,
    output logic       se_in_force,
    output logic       clk_src_ref,
    output logic       deser_en,
    output logic       word_clk_hi,
    output logic       capture_en
);
    pwr_state_t state;
    logic       ref_valid;
    logic       src_ref;
    logic       los_armed;
    logic       lock_ok;
    logic       active;
    logic       any_en;

    serdes_ref_detect #(
        .WIN_CYCLES (WIN_CYCLES),
        .MIN_EDGES  (MIN_EDGES)
    ) i_ref_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_raw   (ref_clk_in),
        .ref_valid (ref_valid)
    );

    serdes_pwr_fsm i_pwr_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .ref_valid (ref_valid),
        .state     (state),
        .src_ref   (src_ref),
        .los_armed (los_armed)
    );

    serdes_lock_qual #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) i_lock_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (pll_en),
        .pll_locked (pll_locked),
        .lock_ok    (lock_ok)
    );

    // Output decode from state, direction and clock source.
    always_comb begin
        active      = (state == PW_ACTIVE);
        core_rst_n  = (state != PW_OFF);
        se_in_force = (state == PW_OFF);
        se_out_oe   = active;
        clk_src_ref = src_ref;
        pll_en      = active && src_ref && !los_armed;
        diff_out_oe = active && dir_ser;
        diff_in_en  = active && (!dir_ser || !src_ref);
        deser_en    = active && !dir_ser;
        word_clk_hi = active && dir_ser;
        capture_en  = active && dir_ser && (src_ref ? lock_ok : 1'b1);
    end

    assign any_en = diff_out_oe | diff_in_en | deser_en | se_out_oe | pll_en;

    // R1: power-down outputs are quiet one edge after a sleep code.
    a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_SLEEP) |=> (!core_rst_n && !any_en && !capture_en && se_in_force));

    // R2: reset is released at least one edge before any enable rises.
    a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_en) |-> $past(core_rst_n));

    // R10: the PLL runs only in reference-clock mode.
    a_r10_pll_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en |-> clk_src_ref);

    // R8: capture in reference mode follows a sampled lock.
    a_r8_capture_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && clk_src_ref) |-> $past(pll_locked));

    // R9: serialize and deserialize paths are never both live.
    a_r9_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(deser_en && (capture_en || diff_out_oe)));

endmodule

// File: tb/test_serdes_pwr_ctrl.sv
module test_serdes_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WIN    = 16;
    localparam int MINE   = 3;
    localparam int LOCKN  = 5;
    localparam int WDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       dir_ser;
    logic       ref_clk_in;
    logic       pll_locked;
    logic       core_rst_n, pll_en, diff_in_en, diff_out_oe, se_out_oe;
    logic       se_in_force, clk_src_ref, deser_en, word_clk_hi, capture_en;

    int  checks   = 0;
    int  failures = 0;
    int  ref_half = 0;
    int  ref_cnt  = 0;
    bit  done     = 1'b0;

    serdes_pwr_ctrl #(
        .WIN_CYCLES  (WIN),
        .MIN_EDGES   (MINE),
        .LOCK_CYCLES (LOCKN)
    ) i_serdes_pwr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .dir_ser     (dir_ser),
        .ref_clk_in  (ref_clk_in),
        .pll_locked  (pll_locked),
        .core_rst_n  (core_rst_n),
        .pll_en      (pll_en),
        .diff_in_en  (diff_in_en),
        .diff_out_oe (diff_out_oe),
        .se_out_oe   (se_out_oe),
        .se_in_force (se_in_force),
        .clk_src_ref (clk_src_ref),
        .deser_en    (deser_en),
        .word_clk_hi (word_clk_hi),
        .capture_en  (capture_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference generator: toggles every ref_half falling edges, 0 = stopped low.
    initial begin
        ref_clk_in = 1'b0;
        forever begin
            @(negedge clk);
            if (ref_half != 0) begin
                ref_cnt++;
                if (ref_cnt >= ref_half) begin
                    ref_cnt    = 0;
                    ref_clk_in = ~ref_clk_in;
                end
            end else begin
                ref_cnt    = 0;
                ref_clk_in = 1'b0;
            end
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R1", "core_rst_n in reset", core_rst_n, 1'b0);
        check("R1", "pll_en in reset", pll_en, 1'b0);
        check("R1", "diff_out_oe in reset", diff_out_oe, 1'b0);
        check("R1", "se_out_oe in reset", se_out_oe, 1'b0);
        check("R1", "diff_in_en in reset", diff_in_en, 1'b0);
        check("R1", "se_in_force in reset", se_in_force, 1'b1);
        check("R1", "clk_src_ref in reset", clk_src_ref, 1'b0);
    endtask

    task automatic t_powerup_external();
        mode_sel = 2'b01;
        cycles(1);
        check("R2", "core_rst_n release cycle", core_rst_n, 1'b1);
        check("R2", "diff_out_oe release cycle", diff_out_oe, 1'b0);
        check("R2", "diff_in_en release cycle", diff_in_en, 1'b0);
        check("R2", "se_out_oe release cycle", se_out_oe, 1'b0);
        check("R2", "se_in_force release cycle", se_in_force, 1'b0);
        cycles(1);
        check("R4", "clk_src_ref external", clk_src_ref, 1'b0);
        check("R4", "pll_en external", pll_en, 1'b0);
        check("R4", "diff_in_en external", diff_in_en, 1'b1);
        check("R4", "capture_en external", capture_en, 1'b1);
        check("R9", "diff_out_oe serialize", diff_out_oe, 1'b1);
        check("R9", "word_clk_hi serialize", word_clk_hi, 1'b1);
        check("R9", "deser_en serialize", deser_en, 1'b0);
    endtask

    task automatic t_slow_ref();
        ref_half = 8;
        cycles(64);
        check("R3", "slow ref stays external", clk_src_ref, 1'b0);
        check("R10", "slow ref keeps PLL off", pll_en, 1'b0);
        ref_half = 0;
        cycles(40);
    endtask

    task automatic t_ref_switch();
        ref_half = 2;
        cycles(40);
        check("R5", "clk_src_ref after ref", clk_src_ref, 1'b1);
        check("R5", "pll_en after ref", pll_en, 1'b1);
        check("R5", "diff_in_en after ref", diff_in_en, 1'b0);
        check("R8", "capture_en before lock", capture_en, 1'b0);
    endtask

    task automatic t_lock_qual();
        pll_locked = 1'b1;
        cycles(LOCKN - 1);
        check("R8", "capture_en one short of lock count", capture_en, 1'b0);
        cycles(1);
        check("R8", "capture_en at lock count", capture_en, 1'b1);
        pll_locked = 1'b0;
        cycles(1);
        check("R8", "capture_en after lock drop", capture_en, 1'b0);
        pll_locked = 1'b1;
        cycles(2);
        pll_locked = 1'b0;
        cycles(1);
        pll_locked = 1'b1;
        cycles(LOCKN - 1);
        check("R8", "glitch restarts count", capture_en, 1'b0);
        cycles(1);
        check("R8", "capture_en after full run", capture_en, 1'b1);
    endtask

    task automatic t_sticky();
        ref_half = 0;
        cycles(60);
        check("R6", "clk_src_ref after ref stops", clk_src_ref, 1'b1);
        check("R6", "pll_en after ref stops", pll_en, 1'b1);
    endtask

    task automatic t_pd_keep_ref();
        ref_half = 2;
        mode_sel = 2'b00;
        cycles(1);
        check("R1", "core_rst_n power-down", core_rst_n, 1'b0);
        check("R1", "pll_en power-down", pll_en, 1'b0);
        check("R1", "diff_out_oe power-down", diff_out_oe, 1'b0);
        check("R1", "capture_en power-down", capture_en, 1'b0);
        check("R1", "se_in_force power-down", se_in_force, 1'b1);
        cycles(40);
        mode_sel = 2'b10;
        cycles(1);
        check("R7", "clk_src_ref on ref power-up", clk_src_ref, 1'b1);
        check("R10", "pll_en off in release", pll_en, 1'b0);
        cycles(1);
        check("R10", "pll_en with ref power-up", pll_en, 1'b1);
        check("R7", "diff_in_en in ref mode", diff_in_en, 1'b0);
    endtask

    task automatic t_pd_clear();
        ref_half = 0;
        cycles(40);
        mode_sel = 2'b00;
        cycles(5);
        mode_sel = 2'b11;
        cycles(2);
        check("R7", "clk_src_ref after quiet power-up", clk_src_ref, 1'b0);
        check("R10", "pll_en after quiet power-up", pll_en, 1'b0);
        check("R7", "diff_in_en external again", diff_in_en, 1'b1);
    endtask

    task automatic t_deser();
        dir_ser = 1'b0;
        cycles(1);
        check("R9", "deser_en deserialize", deser_en, 1'b1);
        check("R9", "diff_in_en deserialize", diff_in_en, 1'b1);
        check("R9", "diff_out_oe deserialize", diff_out_oe, 1'b0);
        check("R9", "word_clk_hi deserialize", word_clk_hi, 1'b0);
        check("R9", "capture_en deserialize", capture_en, 1'b0);
        dir_ser = 1'b1;
    endtask

    initial begin
        rst_n      = 1'b0;
        mode_sel   = 2'b00;
        dir_ser    = 1'b1;
        pll_locked = 1'b0;
        cycles(4);
        t_reset_state();
        rst_n = 1'b1;
        cycles(40);
        t_powerup_external();
        t_slow_ref();
        t_ref_switch();
        t_lock_qual();
        t_sticky();
        t_pd_keep_ref();
        t_pd_clear();
        t_deser();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule